// File: doc/BRIEF.md
# SPI Target Status Poller

This block repeatedly reads the one-byte status register of a configuration target over SPI until the target stops reporting busy. When a mask is given, it also waits until at least one of the masked status bits is set. A single-cycle start pulse begins a run and latches an 8-bit mask. When the run ends, the block returns the last status byte, raises a one-cycle done pulse, and reports whether the run ended cleanly, with an I/O error, or by running out of attempts.

The block does not drive SPI pins. It issues one-byte full-duplex transfers through a byte-level request/acknowledge interface to an SPI engine. The engine frames every request as its own chip-select transaction. Each status sample is made of two identical transfers, and the byte returned by the first one is thrown away. Deciding when to poll, and what to do with the result, is left to the logic around the block.

Top module: `spi_status_poller`

## Requirements
- R1: Every transfer the block requests carries the status-read command byte 0x00 on `xfer_tx_o`. Each status sample consists of exactly two transfers, each held as a request until its acknowledge.
- R2: Only the byte returned by the second transfer of a sample is used. The first returned byte has no effect, even when it has error or busy bits set.
- R3: If bit 2 (protocol violation) or bit 3 (fault) of a sample is 1, the run ends at that sample with `err_io_o` set and no further transfers. This holds even when bit 0 is also set.
- R4: A sample with bit 0 (busy) set and no error bit causes another sample to start in the cycle after its second acknowledge.
- R5: With a zero mask, the run ends cleanly at the first sample that has bit 0 clear and no error bit.
- R6: With a non-zero mask, a sample that is not busy and has no error ends the run cleanly only if it has at least one masked bit set. Otherwise another sample follows. Bit 1 (ready) is the usual mask bit.
- R7: When MAX_TRIES samples have been taken without ending the run, it ends with `err_timeout_o` set and no further transfers.
- R8: `done_o` is high for exactly one cycle: the cycle after the acknowledge of the final transfer. `status_o` then holds the final sample. The two error flags hold their values until the next accepted start, which clears them.
- R9: A start pulse that arrives while a run is in progress is ignored. Neither the attempt count nor the latched mask changes.
- R10: After reset, the block is idle: `busy_o`, `xfer_req_o`, `done_o` and both error flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| mask_i | input | 8 | Required status bits, latched on accepted start |
| xfer_req_o | output | 1 | Request one framed one-byte transfer |
| xfer_tx_o | output | 8 | Byte to shift out |
| xfer_ack_i | input | 1 | One-cycle transfer completion |
| xfer_rx_i | input | 8 | Byte shifted in, valid with acknowledge |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle run completion pulse |
| status_o | output | 8 | Last used status byte |
| err_io_o | output | 1 | Run ended on an error status bit |
| err_timeout_o | output | 1 | Run ended after MAX_TRIES samples |

## Verification
The bench builds the block with MAX_TRIES set to 6. This brings the attempt limit within a few hundred cycles, so a test can exhaust it exactly, including a run where a start pulse lands mid-run. The bench's SPI engine model answers every first transfer with a byte that has busy and both error bits set. Because of this, any use of the discarded byte shows up as a wrong outcome. Scripted second bytes exercise busy retries, both mask behaviours, errors that arrive together with busy, and the timeout. Each of these is checked for its sample count, final byte, flags and done timing.

// File: rtl/spoll_pkg.sv
package spoll_pkg;
  localparam int BIT_BUSY  = 0;
  localparam int BIT_READY = 1;
  localparam int BIT_VIOL  = 2;
  localparam int BIT_FAULT = 3;

  typedef enum logic [1:0] {
    VERD_RETRY = 2'd0,
    VERD_OK    = 2'd1,
    VERD_FAULT = 2'd2
  } verdict_t;

  // Error bits win over busy; busy wins over mask matching.
  function automatic verdict_t judge(input logic [7:0] s, input logic [7:0] m);
    if (s[BIT_VIOL] || s[BIT_FAULT]) return VERD_FAULT;
    if (s[BIT_BUSY]) return VERD_RETRY;
    if ((m == 8'h00) || ((s & m) != 8'h00)) return VERD_OK;
    return VERD_RETRY;
  endfunction
endpackage

// File: rtl/spoll_pair_seq.sv
module spoll_pair_seq #(
  parameter logic [7:0] CMD = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic       xfer_ack,
  input  logic [7:0] xfer_rx,
  output logic       xfer_req,
  output logic [7:0] xfer_tx,
  output logic       smp_valid,
  output logic [7:0] smp_byte
);
  typedef enum logic [1:0] {SQ_IDLE, SQ_DISCARD, SQ_KEEP} sq_t;
  sq_t st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= SQ_IDLE;
    else begin
      case (st)
        SQ_IDLE:    if (go) st <= SQ_DISCARD;
        SQ_DISCARD: if (xfer_ack) st <= SQ_KEEP;
        SQ_KEEP:    if (xfer_ack) st <= go ? SQ_DISCARD : SQ_IDLE;
        default:    st <= SQ_IDLE;
      endcase
    end
  end

  assign xfer_req  = (st != SQ_IDLE);
  assign xfer_tx   = CMD;
  assign smp_valid = (st == SQ_KEEP) && xfer_ack;
  assign smp_byte  = xfer_rx;
endmodule

// File: rtl/spoll_retry.sv
module spoll_retry #(
  parameter int MAX_TRIES = 10000,
  localparam int CNT_W = $clog2(MAX_TRIES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic step,
  output logic last
);
  logic [CNT_W-1:0] remaining;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) remaining <= '0;
    else if (load) remaining <= CNT_W'(MAX_TRIES);
    else if (step) remaining <= remaining - CNT_W'(1);
  end

  assign last = (remaining == CNT_W'(1));
endmodule

// File: rtl/spi_status_poller.sv
module spi_status_poller #(
  parameter int MAX_TRIES = 10000,
  parameter logic [7:0] CMD = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [7:0] mask_i,
  output logic       xfer_req_o,
  output logic [7:0] xfer_tx_o,
  input  logic       xfer_ack_i,
  input  logic [7:0] xfer_rx_i,
  output logic       busy_o,
  output logic       done_o,
  output logic [7:0] status_o,
  output logic       err_io_o,
  output logic       err_timeout_o
);
  import spoll_pkg::*;

  logic       run_q, done_q, io_q, to_q;
  logic [7:0] mask_q, status_q;
  logic       accept, smp_valid, last, cont, finish, exhaust;
  logic [7:0] smp_byte;
  verdict_t   verdict;

  assign accept  = start_i && !run_q;
  assign verdict = judge(smp_byte, mask_q);
  assign cont    = smp_valid && (verdict == VERD_RETRY) && !last;
  assign exhaust = smp_valid && (verdict == VERD_RETRY) && last;
  assign finish  = smp_valid && !cont;

  spoll_pair_seq #(.CMD(CMD)) u_seq (
    .clk(clk), .rst_n(rst_n), .go(accept || cont),
    .xfer_ack(xfer_ack_i), .xfer_rx(xfer_rx_i),
    .xfer_req(xfer_req_o), .xfer_tx(xfer_tx_o),
    .smp_valid(smp_valid), .smp_byte(smp_byte)
  );

  spoll_retry #(.MAX_TRIES(MAX_TRIES)) u_retry (
    .clk(clk), .rst_n(rst_n), .load(accept), .step(cont), .last(last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      done_q   <= 1'b0;
      io_q     <= 1'b0;
      to_q     <= 1'b0;
      mask_q   <= 8'h00;
      status_q <= 8'h00;
    end else begin
      done_q <= finish;
      if (accept) begin
        run_q  <= 1'b1;
        mask_q <= mask_i;
        io_q   <= 1'b0;
        to_q   <= 1'b0;
      end else if (finish) begin
        run_q <= 1'b0;
        io_q  <= (verdict == VERD_FAULT);
        to_q  <= exhaust;
      end
      if (smp_valid) status_q <= smp_byte;
    end
  end

  assign busy_o        = run_q;
  assign done_o        = done_q;
  assign status_o      = status_q;
  assign err_io_o      = io_q;
  assign err_timeout_o = to_q;
endmodule

// File: rtl/spi_status_poller_chk.sv
module spi_status_poller_chk #(
  parameter int MAX_TRIES = 10000,
  parameter logic [7:0] CMD = 8'h00
) (
  input logic       clk,
  input logic       rst_n,
  input logic       accept,
  input logic       smp_valid,
  input logic       xfer_req_o,
  input logic [7:0] xfer_tx_o,
  input logic       xfer_ack_i,
  input logic       busy_o,
  input logic       done_o,
  input logic       err_io_o,
  input logic       err_timeout_o
);
  localparam int CW = $clog2(MAX_TRIES + 1) + 1;
  logic [CW-1:0] taken;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) taken <= '0;
    else if (accept) taken <= '0;
    else if (smp_valid) taken <= taken + CW'(1);
  end

  AST_CMD_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req_o |-> (xfer_tx_o == CMD)); // R1
  AST_REQ_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_req_o |-> busy_o); // R10
  AST_DONE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(xfer_ack_i)); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R8
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err_io_o, err_timeout_o})); // R3
  AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!xfer_req_o && !busy_o)); // R7
  AST_TRY_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> (taken < CW'(MAX_TRIES))); // R7
  AST_TIMEOUT_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && err_timeout_o) |-> (taken == CW'(MAX_TRIES))); // R7
endmodule

bind spi_status_poller spi_status_poller_chk #(.MAX_TRIES(MAX_TRIES), .CMD(CMD)) u_chk (
  .clk(clk), .rst_n(rst_n), .accept(accept), .smp_valid(smp_valid),
  .xfer_req_o(xfer_req_o), .xfer_tx_o(xfer_tx_o), .xfer_ack_i(xfer_ack_i),
  .busy_o(busy_o), .done_o(done_o), .err_io_o(err_io_o),
  .err_timeout_o(err_timeout_o)
);

// File: tb/spi_status_poller_test.sv
module spi_status_poller_test;
  localparam int TRIES = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic [7:0] mask_i = 8'h00;
  logic       xfer_req_o, xfer_ack_i = 1'b0;
  logic [7:0] xfer_tx_o, xfer_rx_i = 8'h00;
  logic       busy_o, done_o, err_io_o, err_timeout_o;
  logic [7:0] status_o;

  int checks = 0, fails = 0;
  int cyc = 0, ack_cyc = 0;
  int xfer_cnt = 0, bad_tx = 0;
  logic [7:0] resp [16];
  int resp_n = 1;

  always #5 clk = ~clk;

  spi_status_poller #(.MAX_TRIES(TRIES)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .mask_i(mask_i),
    .xfer_req_o(xfer_req_o), .xfer_tx_o(xfer_tx_o),
    .xfer_ack_i(xfer_ack_i), .xfer_rx_i(xfer_rx_i),
    .busy_o(busy_o), .done_o(done_o), .status_o(status_o),
    .err_io_o(err_io_o), .err_timeout_o(err_timeout_o)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (xfer_ack_i) ack_cyc <= cyc + 1;
  end

  // SPI engine model: first byte of each pair is junk with busy and error bits
  initial begin
    forever begin
      @(negedge clk);
      if (xfer_req_o) begin
        repeat (2) @(negedge clk);
        if (xfer_tx_o != 8'h00) bad_tx++;
        xfer_ack_i = 1'b1;
        if (xfer_cnt % 2 == 0) xfer_rx_i = 8'h0D;
        else xfer_rx_i = resp[((xfer_cnt / 2) < resp_n) ? (xfer_cnt / 2) : (resp_n - 1)];
        @(negedge clk);
        xfer_ack_i = 1'b0;
        xfer_cnt++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse_start(input logic [7:0] m);
    @(negedge clk);
    start_i = 1'b1; mask_i = m;
    @(negedge clk);
    start_i = 1'b0; mask_i = 8'h00;
  endtask

  // Runs one poll and checks sample count, status byte, flags and done timing.
  task automatic run_poll(input logic [7:0] m, input int exp_smp, input logic [7:0] exp_st,
                          input bit exp_io, input bit exp_to, input string req);
    int n;
    xfer_cnt = 0; bad_tx = 0;
    pulse_start(m);
    chk(err_io_o == 0 && err_timeout_o == 0, "R8 flags cleared on start",
        {err_io_o, err_timeout_o}, 0);
    n = 0;
    while (!done_o && n < 2000) begin @(negedge clk); n++; end
    chk(done_o == 1, {req, " done seen"}, done_o, 1);
    chk(cyc == ack_cyc, "R8 done one cycle after final ack", cyc, ack_cyc);
    chk(xfer_cnt == 2 * exp_smp, {req, " transfer count"}, xfer_cnt, 2 * exp_smp);
    chk(status_o == exp_st, {req, " status byte"}, status_o, exp_st);
    chk(err_io_o == exp_io, {req, " err_io"}, err_io_o, exp_io);
    chk(err_timeout_o == exp_to, {req, " err_timeout"}, err_timeout_o, exp_to);
    chk(bad_tx == 0, "R1 command byte", bad_tx, 0);
    @(negedge clk);
    chk(done_o == 0, "R8 done single cycle", done_o, 0);
    repeat (8) @(negedge clk);
    chk(!xfer_req_o && xfer_cnt == 2 * exp_smp, {req, " no transfers after end"}, xfer_cnt, 2 * exp_smp);
    chk(err_io_o == exp_io && err_timeout_o == exp_to, "R8 flags held",
        {err_io_o, err_timeout_o}, {exp_io, exp_to});
  endtask

  task automatic t_reset;
    chk(!busy_o && !xfer_req_o && !done_o && !err_io_o && !err_timeout_o,
        "R10 reset state", {busy_o, xfer_req_o, done_o, err_io_o, err_timeout_o}, 0);
  endtask

  task automatic t_busy_then_idle; // R4 R2 R5
    resp[0] = 8'h01; resp[1] = 8'h01; resp[2] = 8'h00; resp_n = 3;
    run_poll(8'h00, 3, 8'h00, 0, 0, "R4");
  endtask

  task automatic t_first_idle; // R5 R2 (junk first byte ignored)
    resp[0] = 8'h10; resp_n = 1;
    run_poll(8'h00, 1, 8'h10, 0, 0, "R5");
  endtask

  task automatic t_mask_wait; // R6
    resp[0] = 8'h01; resp[1] = 8'h00; resp[2] = 8'h10; resp[3] = 8'h02; resp_n = 4;
    run_poll(8'h02, 4, 8'h02, 0, 0, "R6");
  endtask

  task automatic t_mask_other; // R6
    resp[0] = 8'h10; resp[1] = 8'h20; resp_n = 2;
    run_poll(8'h30, 1, 8'h10, 0, 0, "R6 any masked bit");
  endtask

  task automatic t_errors; // R3
    resp[0] = 8'h01; resp[1] = 8'h05; resp_n = 2;
    run_poll(8'h00, 2, 8'h05, 1, 0, "R3 violation with busy");
    resp[0] = 8'h0A; resp_n = 1;
    run_poll(8'h02, 1, 8'h0A, 1, 0, "R3 fault");
  endtask

  task automatic t_timeout; // R7
    resp[0] = 8'h01; resp_n = 1;
    run_poll(8'h00, TRIES, 8'h01, 0, 1, "R7 busy forever");
    resp[0] = 8'h00; resp_n = 1;
    run_poll(8'h80, TRIES, 8'h00, 0, 1, "R7 mask never met");
  endtask

  task automatic t_start_ignored; // R9
    int n;
    resp[0] = 8'h01; resp[1] = 8'h01; resp[2] = 8'h40; resp_n = 3;
    xfer_cnt = 0;
    pulse_start(8'h02);
    n = 0;
    while (xfer_cnt < 5 && n < 500) begin @(negedge clk); n++; end
    pulse_start(8'h40);
    n = 0;
    while (!done_o && n < 2000) begin @(negedge clk); n++; end
    chk(done_o && xfer_cnt == 2 * TRIES, "R9 mid-run start ignored", xfer_cnt, 2 * TRIES);
    chk(err_timeout_o == 1, "R9 latched mask kept", err_timeout_o, 1);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_busy_then_idle();
    t_first_idle();
    t_mask_wait();
    t_mask_other();
    t_errors();
    t_timeout();
    t_start_ignored();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule